// File: doc/BRIEF.md
# I2S Slave Audio Transceiver

This block sits on the fabric side of a serial audio link to an external codec that is the clock master. The codec drives the bit clock and the left/right channel select. The block has no audio clock of its own. It runs entirely in one system clock, 50 MHz in the target system. It oversamples the bit clock, the channel select and the serial ADC line, and finds the bit-clock edges from those samples.

On the receive side it assembles 24-bit left and right samples from the ADC line. It presents each completed stereo pair on parallel outputs with a one-cycle valid strobe. On the transmit side it takes one 24-bit left/right pair per frame and shifts it out on the DAC line. The codec's bit clock is 48 kHz × 24 bits × 2 channels = 2.304 MHz, well below the system clock, so every codec edge is seen over several system cycles.

Top module: `i2s_slave_xcvr`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears its state: codec_dac, rx_valid and tx_ready read 0, and rx_left and rx_right read 0.
- R2: After reset, no sample is assembled and rx_valid stays 0 until the channel select has been seen to change at a bit-clock rising edge.
- R3: Channel select low (0) marks the left word and high (1) marks the right word. Received bits are taken at bit-clock rising edges. The MSB is the bit at the second rising edge after the select changes, and the following 23 rising edges carry the remaining bits in descending order.
- R4: When a right word completes after a left word of the same frame, rx_valid is high for exactly one system cycle with the pair on rx_left/rx_right. Those outputs then hold until the next pair.
- R5: When a channel lasts more than 24 bit-clock periods, received bits after the 24th are ignored.
- R6: codec_dac changes only after a bit-clock falling edge. The MSB of a word is driven from the first falling edge after the rising edge at which the select change is seen, so the codec samples it at the next rising edge.
- R7: After the 24th bit of a word, codec_dac is driven 0 for the rest of that channel.
- R8: At the start of each left word the block takes tx_left and tx_right, and tx_ready is high for exactly one cycle just after. If the inputs are left unchanged, the same pair is sent again in the next frame.
- R9: After reset, codec_dac stays 0 until the first channel-select change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| codec_bclk | input | 1 | Bit clock driven by the codec, asynchronous |
| codec_lrsel | input | 1 | Channel select driven by the codec (0 left, 1 right) |
| codec_adc | input | 1 | Serial ADC data from the codec |
| codec_dac | output | 1 | Serial DAC data to the codec |
| tx_left | input | 24 | Left playback sample |
| tx_right | input | 24 | Right playback sample |
| tx_ready | output | 1 | One-cycle pulse: the playback pair has been taken |
| rx_left | output | 24 | Last received left sample |
| rx_right | output | 24 | Last received right sample |
| rx_valid | output | 1 | One-cycle pulse: a new received pair is on rx_left/rx_right |

## Verification
The bench plays a codec model with a 24-slot channel and with a 32-slot channel. The long channel carries ones in the surplus slots. A receiver that keeps shifting past bit 24 returns corrupted samples, and a transmitter that does not stop after bit 24 leaks nonzero bits into those slots. Each word's LSB lands in the first slot of the following channel. An alignment error of one slot therefore shows up as every sample shifted by one bit. A run in which the channel select never changes checks that a design which arms on the first edge it sees does not produce spurious pairs or DAC bits. A run with frozen playback inputs checks that the same pair is sent again.

// File: rtl/i2s_pkg.sv
// Shared definitions for the I2S slave transceiver.
package i2s_pkg;
    // Bits carried per channel word.
    localparam int unsigned I2S_SAMPLE_W = 24;

    // Channel named by the channel-select level.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/i2s_in_sync.sv
// Multi-flop synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent, or slow enough relative to clk that a
// one-cycle skew between bits does no harm.
module i2s_in_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Shift the raw input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_async[g]};
            end
            assign d_sync[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2s_frame_track.sv
// Finds bit-clock edges in the synchronised bit clock and flags the rising
// edge at which the channel select is first seen at a new level.
// Assumes the bit clock is at least a few system cycles per half period.
module i2s_frame_track
    import i2s_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bclk_s,
    input  logic  lrsel_s,
    output logic  bclk_rise,
    output logic  bclk_fall,
    output logic  word_start,
    output chan_e word_chan
);
    logic bclk_d;
    logic lr_prev;
    logic seen;

    // Remember the last bit-clock level and the select seen at rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d  <= 1'b0;
            lr_prev <= 1'b0;
            seen    <= 1'b0;
        end else begin
            bclk_d <= bclk_s;
            if (bclk_rise) begin
                lr_prev <= lrsel_s;
                seen    <= 1'b1;
            end
        end
    end

    assign bclk_rise  = bclk_s & ~bclk_d;
    assign bclk_fall  = ~bclk_s & bclk_d;
    assign word_start = bclk_rise & seen & (lrsel_s != lr_prev);
    assign word_chan  = chan_e'(lrsel_s);
endmodule

// File: rtl/i2s_rx_deser.sv
// Receive deserialiser: takes one bit per bit-clock rising edge, counts 24
// bits after each word start, and publishes left/right pairs.
// Assumes word_start and bit_rise come from the same edge detector.
module i2s_rx_deser
    import i2s_pkg::*;
#(
    parameter int DATA_W = I2S_SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              word_start,
    input  chan_e             word_chan,
    input  logic              sd_bit,
    output logic [DATA_W-1:0] rx_left,
    output logic [DATA_W-1:0] rx_right,
    output logic              rx_valid
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] FULL = CW'(DATA_W);

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] word_now;
    logic [DATA_W-1:0] left_buf;
    logic [CW-1:0]     cnt;
    chan_e             cur_chan;
    logic              left_ok;

    assign word_now = {shreg[DATA_W-2:0], sd_bit};

    // Shift bits in, close words at bit 24, pair left with right.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            left_buf <= '0;
            cnt      <= FULL;
            cur_chan <= CH_LEFT;
            left_ok  <= 1'b0;
            rx_left  <= '0;
            rx_right <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (bit_rise && cnt < FULL) begin
                shreg <= word_now;
                cnt   <= cnt + 1'b1;
                if (cnt == FULL - 1'b1) begin
                    if (cur_chan == CH_LEFT) begin
                        left_buf <= word_now;
                        left_ok  <= 1'b1;
                    end else if (left_ok) begin
                        rx_left  <= left_buf;
                        rx_right <= word_now;
                        rx_valid <= 1'b1;
                        left_ok  <= 1'b0;
                    end
                end
            end
            if (word_start) begin
                cnt      <= '0;
                cur_chan <= word_chan;
                if (word_chan == CH_LEFT) left_ok <= 1'b0;
            end
        end
    end

    // R4: the pair strobe never lasts two cycles.
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R4: outputs move only together with the strobe.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable({rx_left, rx_right}) || rx_valid);
endmodule

// File: rtl/i2s_tx_ser.sv
// Transmit serialiser: loads a word at each word start (taking a new pair at
// left starts) and shifts one bit out per bit-clock falling edge, then zeros.
// Assumes a word start never coincides with a falling edge.
module i2s_tx_ser
    import i2s_pkg::*;
#(
    parameter int DATA_W = I2S_SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_fall,
    input  logic              word_start,
    input  chan_e             word_chan,
    input  logic [DATA_W-1:0] tx_left,
    input  logic [DATA_W-1:0] tx_right,
    output logic              tx_ready,
    output logic              sd_out
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] FULL = CW'(DATA_W);

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] right_hold;
    logic [CW-1:0]     cnt;

    // Load words at word starts; drive one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            right_hold <= '0;
            cnt        <= FULL;
            tx_ready   <= 1'b0;
            sd_out     <= 1'b0;
        end else begin
            tx_ready <= 1'b0;
            if (word_start) begin
                cnt <= '0;
                if (word_chan == CH_LEFT) begin
                    shreg      <= tx_left;
                    right_hold <= tx_right;
                    tx_ready   <= 1'b1;
                end else begin
                    shreg <= right_hold;
                end
            end else if (bit_fall) begin
                if (cnt < FULL) begin
                    sd_out <= shreg[DATA_W-1];
                    shreg  <= {shreg[DATA_W-2:0], 1'b0};
                    cnt    <= cnt + 1'b1;
                end else begin
                    sd_out <= 1'b0;
                end
            end
        end
    end

    // R6: the serial output moves only after a detected falling edge.
    a_r6_dac_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_out) |-> $past(bit_fall));
    // R7: past the last bit the line is driven low.
    a_r7_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_fall && !word_start && cnt == FULL) |=> !sd_out);
    // R8: the take strobe is a single cycle.
    a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);
endmodule

// File: rtl/i2s_slave_xcvr.sv
// Full-duplex I2S slave: synchronises the codec-driven bit clock, channel
// select and ADC line, tracks frames, and runs the receive and transmit
// paths. Assumes the codec is the clock master and the system clock is
// several times faster than the bit clock.
module i2s_slave_xcvr
    import i2s_pkg::*;
#(
    parameter int DATA_W      = I2S_SAMPLE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              codec_bclk,
    input  logic              codec_lrsel,
    input  logic              codec_adc,
    output logic              codec_dac,
    input  logic [DATA_W-1:0] tx_left,
    input  logic [DATA_W-1:0] tx_right,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_left,
    output logic [DATA_W-1:0] rx_right,
    output logic              rx_valid
);
    logic [2:0] pins_s;
    logic       bclk_rise;
    logic       bclk_fall;
    logic       word_start;
    chan_e      word_chan;

    i2s_in_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({codec_adc, codec_lrsel, codec_bclk}),
        .d_sync  (pins_s)
    );

    i2s_frame_track u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_s     (pins_s[0]),
        .lrsel_s    (pins_s[1]),
        .bclk_rise  (bclk_rise),
        .bclk_fall  (bclk_fall),
        .word_start (word_start),
        .word_chan  (word_chan)
    );

    i2s_rx_deser #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_rise   (bclk_rise),
        .word_start (word_start),
        .word_chan  (word_chan),
        .sd_bit     (pins_s[2]),
        .rx_left    (rx_left),
        .rx_right   (rx_right),
        .rx_valid   (rx_valid)
    );

    i2s_tx_ser #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_fall   (bclk_fall),
        .word_start (word_start),
        .word_chan  (word_chan),
        .tx_left    (tx_left),
        .tx_right   (tx_right),
        .tx_ready   (tx_ready),
        .sd_out     (codec_dac)
    );
endmodule

// File: tb/i2s_slave_xcvr_tb.sv
// Directed bench: a codec model plays slot arrays onto the link and records
// the DAC line at each rising edge.
module i2s_slave_xcvr_tb;
    localparam int HALF  = 8;
    localparam int NSLOT = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b1, lrsel = 1'b1, adc = 1'b0;
    logic dac, tx_ready, rx_valid;
    logic [23:0] tx_left = '0, tx_right = '0, rx_left, rx_right;

    int  n_tests = 0, n_fail = 0;
    bit  done = 0;

    bit ws_seq [NSLOT];
    bit sd_seq [NSLOT];
    bit cap    [NSLOT];
    logic [23:0] rxw_l [8], rxw_r [8], txv_l [8], txv_r [8], got_l [8], got_r [8];
    int  nrx = 0, ntx = 0, pulse_long = 0;
    bit  freeze = 0, prev_valid = 0, prev_ready = 0;

    always #2.5 clk = ~clk;

    i2s_slave_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .codec_bclk(bclk), .codec_lrsel(lrsel),
        .codec_adc(adc), .codec_dac(dac), .tx_left(tx_left), .tx_right(tx_right),
        .tx_ready(tx_ready), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
    );

    // Record received pairs and serve playback pairs on each take strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((rx_valid && prev_valid) || (tx_ready && prev_ready)) pulse_long++;
            if (rx_valid && nrx < 8) begin
                got_l[nrx] = rx_left; got_r[nrx] = rx_right; nrx++;
            end
            if (tx_ready) begin
                ntx++;
                if (!freeze && ntx < 8) begin
                    tx_left = txv_l[ntx]; tx_right = txv_r[ntx];
                end
            end
            prev_valid = rx_valid; prev_ready = tx_ready;
        end
    end

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bclk = 1'b1; lrsel = 1'b1; adc = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        chk("R1 reset outputs", {20'd0, dac, rx_valid, tx_ready, 1'b0, rx_left}, 48'd0);
        chk("R1 reset right", {24'd0, rx_right}, 48'd0);
        nrx = 0; ntx = 0; pulse_long = 0; prev_valid = 0; prev_ready = 0;
        rst_n = 1'b1;
    endtask

    // Fill the slot arrays: 24 pre-roll slots on the right, nfr frames of chlen
    // slots per channel, then 24 trailing left slots. Surplus slots carry ones.
    task automatic gen(input int nfr, input int chlen, input bit arm, output int nslots);
        nslots = 48 + nfr * 2 * chlen;
        for (int i = 0; i < NSLOT; i++) begin
            ws_seq[i] = 1'b1; sd_seq[i] = 1'b1; cap[i] = 1'b0;
        end
        if (arm) begin
            for (int k = 0; k < nfr; k++)
                for (int i = 0; i < chlen; i++) ws_seq[24 + 2*k*chlen + i] = 1'b0;
            for (int i = 0; i < 24; i++) ws_seq[24 + 2*nfr*chlen + i] = 1'b0;
            for (int k = 0; k < nfr; k++) begin
                rxw_l[k] = 24'hA5C300 + 24'(k) * 24'h01F3D1;
                rxw_r[k] = ~rxw_l[k] ^ 24'(k * 3);
                for (int b = 0; b < 24; b++) begin
                    sd_seq[24 + 2*k*chlen + 1 + b]         = rxw_l[k][23-b];
                    sd_seq[24 + 2*k*chlen + chlen + 1 + b] = rxw_r[k][23-b];
                end
            end
        end
    endtask

    task automatic play(input int n);
        for (int i = 0; i < n; i++) begin
            repeat (HALF) @(posedge clk);
            #1 bclk = 1'b0; lrsel = ws_seq[i]; adc = sd_seq[i];
            repeat (HALF) @(posedge clk);
            #1 cap[i] = dac; bclk = 1'b1;
        end
        repeat (20) @(posedge clk);
        #1;
    endtask

    function automatic logic [23:0] word_at(input int p);
        logic [23:0] w = '0;
        for (int b = 0; b < 24; b++) w[23-b] = cap[p + b];
        return w;
    endfunction

    // Run nfr frames of chlen slots and check both directions.
    task automatic run_frames(input int nfr, input int chlen, input bit frz, input string tag);
        int n, tail_ones;
        for (int k = 0; k < 8; k++) begin
            txv_l[k] = 24'h800001 ^ (24'(k) * 24'h0B1357);
            txv_r[k] = 24'h13579B + 24'(k) * 24'h202020;
        end
        do_reset();
        freeze = frz; tx_left = txv_l[0]; tx_right = txv_r[0];
        gen(nfr, chlen, 1'b1, n);
        play(n);
        chk({"R4 pair count ", tag}, 48'(nrx), 48'(nfr));
        chk({"R4 R8 one-cycle strobes ", tag}, 48'(pulse_long), 48'd0);
        for (int k = 0; k < nfr; k++)
            chk({"R3 R5 rx pair ", tag}, {got_l[k], got_r[k]}, {rxw_l[k], rxw_r[k]});
        chk({"R4 hold after last pair ", tag}, {rx_left, rx_right}, {rxw_l[nfr-1], rxw_r[nfr-1]});
        chk({"R8 take count ", tag}, 48'(ntx), 48'(nfr + 1));
        chk({"R9 dac idle before arming ", tag}, 48'(word_at(1)) | 48'(cap[0]), 48'd0);
        for (int k = 0; k < nfr; k++) begin
            int p = 24 + 2*k*chlen;
            int e = frz ? 0 : k;
            chk({"R6 R8 dac words ", tag}, {word_at(p + 1), word_at(p + chlen + 1)},
                {txv_l[e], txv_r[e]});
            tail_ones = 0;
            for (int i = 25; i < chlen; i++) tail_ones += cap[p + i] + cap[p + chlen + i];
            chk({"R7 zero tail ", tag}, 48'(tail_ones), 48'd0);
        end
    endtask

    task automatic t_reset();
        do_reset();
        repeat (3) @(posedge clk);
        #1 chk("R1 outputs just after reset", {dac, rx_valid, tx_ready}, 48'd0);
    endtask

    task automatic t_no_transition();
        int n, ones;
        do_reset();
        gen(2, 24, 1'b0, n);
        play(n);
        chk("R2 no pair without select change", 48'(nrx), 48'd0);
        ones = 0;
        for (int i = 0; i < n; i++) ones += cap[i];
        chk("R9 dac low without select change", 48'(ones), 48'd0);
        chk("R8 no take without select change", 48'(ntx), 48'd0);
    endtask

    initial begin
        t_reset();
        t_no_transition();
        run_frames(4, 24, 1'b0, "24-slot");
        run_frames(3, 32, 1'b1, "32-slot frozen");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule